// File: doc/BRIEF.md
# Prescaled Auto-Reload Compare Timer

This block is a 32-bit up-counting timer core. Software writes a handful of registers through a simple one-cycle write port: a control word, the counter itself, a reload value, a compare value, a reload trigger, an interrupt-flag clear and an interrupt enable mask. While running, the counter advances either on every clock or once per period of a power-of-two prescaler. When it steps past all-ones it either reloads from the reload register or wraps to zero.

A compare unit watches every step of the counter and signals a match when the counter moves onto the compare value. Overflow and match each produce a one-cycle pulse. The pulses are brought out for a separate waveform generator, and each one also sets a sticky interrupt flag that can be masked.

The prescaler is cleared in four situations: a reload on overflow, a direct write to the counter, a trigger write, and a stop. After any of these, a full prescaler period elapses before the next count.

Top module: `prescaled_reload_timer`

## Requirements
- R1: After reset the counter reads 0, both pulses are low, both flags are 0 and irq is low.
- R2: Control word bit 0 is the run bit. With run=1 and the prescaler disabled, the counter advances by one on every clock. With run=0 the counter holds its value.
- R3: Control bit 5 enables the prescaler and control bits 4:2 hold the ratio r. When enabled, the counter advances once every 2^(r+1) clocks, so r=0 divides by 2 and r=7 divides by 256.
- R4: A write to address 1 loads the written data into the counter on the next edge and clears the prescaler. Such a write takes priority over a count step in the same cycle.
- R5: A write of any data to address 4 reloads the counter from the reload register (address 2) and clears the prescaler.
- R6: Clearing the run bit clears the prescaler. After a restart, the first count comes a full prescaler period later.
- R7: A count step from all-ones produces a one-cycle ovfPulse, shown together with the new counter value. Control bit 1 selects what the counter takes at that step: the reload register when set, 0 when clear. A reload on overflow clears the prescaler.
- R8: Control bit 6 enables compare. While it is set, a count step onto the compare value (address 3) produces a one-cycle matchPulse, shown together with that counter value. While it is clear, no matchPulse occurs.
- R9: The compare register may be written while the counter runs or while it is stopped. The new value applies to the counts that follow.
- R10: irqFlags bit 0 (overflow) and bit 1 (match) set on the clock edge after the corresponding pulse and stay set. Writing 1 to a bit at address 5 clears that flag. A pulse in the same cycle as its clear wins, so the flag stays set.
- R11: irq is high when any flag is set whose enable bit is also set. The enable bits are written at address 6, with bit 0 for overflow and bit 1 for match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 32 | Write data |
| count | output | 32 | Current counter value |
| ovfPulse | output | 1 | One-cycle overflow event |
| matchPulse | output | 1 | One-cycle compare match event |
| irqFlags | output | 2 | Sticky flags {match, overflow} |
| irq | output | 1 | Masked interrupt request |

## Verification
Two pairs of functions can fall in the same cycle. A flag clear can arrive together with a new event on that flag. A counter or trigger write can arrive together with a prescaler tick or an overflow step. The bench provokes the first case by watching its reference model for the overflow pulse and issuing the flag clear in exactly that cycle. It provokes the second case by writing the counter and the trigger at points inside a running prescaler period. The bench compares the counter, both pulses, the flags and irq against its reference model on every clock. The outcome is judged on whether the flag stays set and whether the written value wins over the step.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int RATIO_W = 3;
  localparam int ADDR_W  = 3;

  // register addresses
  localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
  localparam logic [ADDR_W-1:0] A_COUNT   = 3'd1;
  localparam logic [ADDR_W-1:0] A_LOAD    = 3'd2;
  localparam logic [ADDR_W-1:0] A_MATCH   = 3'd3;
  localparam logic [ADDR_W-1:0] A_TRIG    = 3'd4;
  localparam logic [ADDR_W-1:0] A_FLAGCLR = 3'd5;
  localparam logic [ADDR_W-1:0] A_IEN     = 3'd6;

  // control word bit positions
  localparam int B_RUN   = 0;
  localparam int B_AUTO  = 1;
  localparam int B_RATIO = 2;
  localparam int B_PRE   = 5;
  localparam int B_CMP   = 6;
  localparam int CTRL_W  = 7;

  typedef struct packed {
    logic               running;
    logic               autoReload;
    logic               preEn;
    logic [RATIO_W-1:0] ratio;
    logic               cmpEn;
    logic               cntWrite;
    logic               trigWrite;
  } tmr_stb_t;
endpackage

// File: rtl/timer_prescaler.sv
module timer_prescaler
  import timer_pkg::*;
#(
  parameter int RW = RATIO_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          running,
  input  logic          enable,
  input  logic [RW-1:0] ratio,
  input  logic          clear,
  output logic          tick
);
  localparam int PRE_W = 1 << RW;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] oneHot;
  logic [PRE_W-1:0] mask;
  logic             hit;

  always_comb begin
    oneHot = PRE_W'(1) << ((RW+1)'(ratio) + (RW+1)'(1));
    mask   = oneHot - PRE_W'(1);
    hit    = (preCnt & mask) == mask;
    tick   = running && (!enable || hit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preCnt <= '0;
    end else if (!running || !enable || clear || tick) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + PRE_W'(1);
    end
  end
endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmr_stb_t         stb,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] loadVal,
  input  logic [WIDTH-1:0] matchVal,
  output logic [WIDTH-1:0] count,
  output logic             ovfPulse,
  output logic             matchPulse
);
  logic             tick;
  logic             atMax;
  logic             stepped;
  logic             reloadOvf;
  logic             preClear;
  logic [WIDTH-1:0] nextCount;

  assign atMax     = (count == {WIDTH{1'b1}});
  assign stepped   = tick && !stb.cntWrite && !stb.trigWrite;
  assign reloadOvf = tick && atMax && stb.autoReload;
  assign preClear  = stb.cntWrite || stb.trigWrite || reloadOvf;

  timer_prescaler #(.RW(RATIO_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .running (stb.running),
    .enable  (stb.preEn),
    .ratio   (stb.ratio),
    .clear   (preClear),
    .tick    (tick)
  );

  always_comb begin
    if (stb.cntWrite) begin
      nextCount = wrData;
    end else if (stb.trigWrite) begin
      nextCount = loadVal;
    end else if (tick) begin
      if (atMax) nextCount = stb.autoReload ? loadVal : '0;
      else       nextCount = count + WIDTH'(1);
    end else begin
      nextCount = count;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count      <= '0;
      ovfPulse   <= 1'b0;
      matchPulse <= 1'b0;
    end else begin
      count      <= nextCount;
      ovfPulse   <= stepped && atMax;
      matchPulse <= stepped && stb.cmpEn && (nextCount == matchVal);
    end
  end
endmodule

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WIDTH-1:0]  wrData,
  input  logic              ovfEvt,
  input  logic              matchEvt,
  output tmr_stb_t          stb,
  output logic [WIDTH-1:0]  loadVal,
  output logic [WIDTH-1:0]  matchVal,
  output logic [1:0]        irqFlags,
  output logic              irq
);
  logic [CTRL_W-1:0] ctrlReg;
  logic [1:0]        ienReg;
  logic [1:0]        clrMask;

  assign clrMask = (wrEn && wrAddr == A_FLAGCLR) ? wrData[1:0] : 2'b00;

  always_comb begin
    stb.running    = ctrlReg[B_RUN];
    stb.autoReload = ctrlReg[B_AUTO];
    stb.preEn      = ctrlReg[B_PRE];
    stb.ratio      = ctrlReg[B_RATIO +: RATIO_W];
    stb.cmpEn      = ctrlReg[B_CMP];
    stb.cntWrite   = wrEn && (wrAddr == A_COUNT);
    stb.trigWrite  = wrEn && (wrAddr == A_TRIG);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrlReg  <= '0;
      loadVal  <= '0;
      matchVal <= '0;
      ienReg   <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        A_CTRL:  ctrlReg  <= wrData[CTRL_W-1:0];
        A_LOAD:  loadVal  <= wrData;
        A_MATCH: matchVal <= wrData;
        A_IEN:   ienReg   <= wrData[1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irqFlags <= 2'b00;
    else        irqFlags <= (irqFlags & ~clrMask) | {matchEvt, ovfEvt};
  end

  assign irq = |(irqFlags & ienReg);
endmodule

// File: rtl/prescaled_reload_timer.sv
module prescaled_reload_timer
  import timer_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WIDTH-1:0]  wrData,
  output logic [WIDTH-1:0]  count,
  output logic              ovfPulse,
  output logic              matchPulse,
  output logic [1:0]        irqFlags,
  output logic              irq
);
  tmr_stb_t         stb;
  logic [WIDTH-1:0] loadVal;
  logic [WIDTH-1:0] matchVal;

  timer_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .ovfEvt   (ovfPulse),
    .matchEvt (matchPulse),
    .stb      (stb),
    .loadVal  (loadVal),
    .matchVal (matchVal),
    .irqFlags (irqFlags),
    .irq      (irq)
  );

  timer_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb        (stb),
    .wrData     (wrData),
    .loadVal    (loadVal),
    .matchVal   (matchVal),
    .count      (count),
    .ovfPulse   (ovfPulse),
    .matchPulse (matchPulse)
  );
endmodule

// File: rtl/timer_checker.sv
module timer_checker
  import timer_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input tmr_stb_t         stb,
  input logic [WIDTH-1:0] wrData,
  input logic [WIDTH-1:0] loadVal,
  input logic [WIDTH-1:0] matchVal,
  input logic [WIDTH-1:0] count,
  input logic             ovfPulse,
  input logic             matchPulse,
  input logic [1:0]       irqFlags
);
  AST_FROZEN_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb.running && !stb.cntWrite && !stb.trigWrite) |=> $stable(count)); // R2

  AST_COUNT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    stb.cntWrite |=> count == $past(wrData)); // R4

  AST_TRIGGER_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    stb.trigWrite |=> count == $past(loadVal)); // R5

  AST_OVF_FROM_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    ovfPulse |-> $past(count) == {WIDTH{1'b1}}); // R7

  AST_OVF_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (ovfPulse && $past(stb.autoReload)) |-> count == $past(loadVal)); // R7

  AST_MATCH_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    matchPulse |-> ($past(stb.cmpEn) && count == $past(matchVal))); // R8

  AST_OVF_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ovfPulse |=> irqFlags[0]); // R10

  AST_MATCH_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    matchPulse |=> irqFlags[1]); // R10
endmodule

bind prescaled_reload_timer timer_checker #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stb        (stb),
  .wrData     (wrData),
  .loadVal    (loadVal),
  .matchVal   (matchVal),
  .count      (count),
  .ovfPulse   (ovfPulse),
  .matchPulse (matchPulse),
  .irqFlags   (irqFlags)
);

// File: tb/prescaled_reload_timer_tb.sv
module prescaled_reload_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wrEn = 1'b0;
  logic [2:0]   wrAddr = 3'd0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] count;
  logic         ovfPulse, matchPulse, irq;
  logic [1:0]   irqFlags;

  int    compared = 0;
  int    mismatched = 0;
  string curReq = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  prescaled_reload_timer #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .count(count), .ovfPulse(ovfPulse), .matchPulse(matchPulse),
    .irqFlags(irqFlags), .irq(irq)
  );

  // behavioural reference model
  logic [6:0]   mCtrl;
  logic [W-1:0] mLoad, mMatch, mCount;
  logic [1:0]   mIen, mFlags;
  logic         mOvf, mMatchP;
  int           mPre;

  always @(posedge clk) begin
    if (!rst_n) begin
      mCtrl = '0; mLoad = '0; mMatch = '0; mCount = '0;
      mIen = '0; mFlags = '0; mOvf = 0; mMatchP = 0; mPre = 0;
    end else begin
      automatic bit run = mCtrl[0];
      automatic bit aut = mCtrl[1];
      automatic int r   = int'(mCtrl[4:2]);
      automatic bit pre = mCtrl[5];
      automatic bit cmp = mCtrl[6];
      automatic int msk = (1 << (r + 1)) - 1;
      automatic bit cw  = wrEn && wrAddr == 3'd1;
      automatic bit tw  = wrEn && wrAddr == 3'd4;
      automatic bit tk  = run && (!pre || ((mPre & msk) == msk));
      automatic bit top = (mCount == 32'hFFFF_FFFF);
      automatic logic [W-1:0] nc;
      automatic logic [1:0] clr = (wrEn && wrAddr == 3'd5) ? wrData[1:0] : 2'b00;
      if (cw) nc = wrData;
      else if (tw) nc = mLoad;
      else if (tk) nc = top ? (aut ? mLoad : '0) : mCount + 1;
      else nc = mCount;
      mFlags = (mFlags & ~clr) | {mMatchP, mOvf};
      mOvf    = tk && !cw && !tw && top;
      mMatchP = tk && !cw && !tw && cmp && (nc == mMatch);
      if (!run || !pre || cw || tw || tk) mPre = 0;
      else mPre = (mPre + 1) & 255;
      mCount = nc;
      if (wrEn) begin
        case (wrAddr)
          3'd0: mCtrl = wrData[6:0];
          3'd2: mLoad = wrData;
          3'd3: mMatch = wrData;
          3'd6: mIen = wrData[1:0];
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h at %0t", curReq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("count", count, mCount);
      chk("ovfPulse", W'(ovfPulse), W'(mOvf));
      chk("matchPulse", W'(matchPulse), W'(mMatchP));
      chk("irqFlags", W'(irqFlags), W'(mFlags));
      chk("irq", W'(irq), W'(|(mFlags & mIen)));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [W-1:0] mkCtrl(input bit run, input bit aut, input int r,
                                          input bit pre, input bit cmp);
    return W'({cmp, pre, 3'(r), aut, run});
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    compared++;
    if (count !== '0 || ovfPulse || matchPulse || irqFlags !== 2'b00 || irq) begin
      mismatched++;
      $display("FAIL R1 reset: actual %h/%b/%b/%b/%b expected 0/0/0/0/0",
               count, ovfPulse, matchPulse, irqFlags, irq);
    end
    idle(2);

    curReq = "R2";
    wr(3'd0, mkCtrl(1, 0, 0, 0, 0)); idle(12);
    wr(3'd0, mkCtrl(0, 0, 0, 0, 0)); idle(6);

    curReq = "R3";
    wr(3'd0, mkCtrl(1, 0, 0, 1, 0)); idle(12);
    wr(3'd0, mkCtrl(1, 0, 2, 1, 0)); idle(40);
    wr(3'd0, mkCtrl(1, 0, 7, 1, 0)); idle(600);

    curReq = "R4";
    wr(3'd0, mkCtrl(1, 0, 3, 1, 0)); idle(7);
    wr(3'd1, 32'h0000_0100); idle(5);
    wr(3'd1, 32'h0000_0200); idle(30);

    curReq = "R5";
    wr(3'd2, 32'h0000_0055); idle(9);
    wr(3'd4, 32'h0); idle(30);

    curReq = "R6";
    idle(5);
    wr(3'd0, mkCtrl(0, 0, 3, 1, 0)); idle(4);
    wr(3'd0, mkCtrl(1, 0, 3, 1, 0)); idle(40);

    curReq = "R7";
    wr(3'd2, 32'h0000_1000);
    wr(3'd0, mkCtrl(1, 1, 0, 0, 0));
    wr(3'd1, 32'hFFFF_FFFC); idle(10);
    wr(3'd0, mkCtrl(1, 1, 1, 1, 0));
    wr(3'd1, 32'hFFFF_FFFD); idle(20);
    wr(3'd0, mkCtrl(1, 0, 0, 0, 0));
    wr(3'd1, 32'hFFFF_FFFE); idle(10);

    curReq = "R8";
    wr(3'd3, 32'h0000_0020);
    wr(3'd0, mkCtrl(1, 0, 0, 0, 1));
    wr(3'd1, 32'h0000_001A); idle(12);
    wr(3'd0, mkCtrl(1, 0, 0, 0, 0));
    wr(3'd1, 32'h0000_001A); idle(12);

    curReq = "R9";
    wr(3'd0, mkCtrl(1, 0, 0, 0, 1));
    wr(3'd1, 32'h0000_0030); idle(3);
    wr(3'd3, 32'h0000_0038); idle(10);
    wr(3'd0, mkCtrl(0, 0, 0, 0, 1));
    wr(3'd3, 32'h0000_0050);
    wr(3'd1, 32'h0000_004C);
    wr(3'd0, mkCtrl(1, 0, 0, 0, 1)); idle(10);

    curReq = "R10";
    wr(3'd5, 32'h3); idle(3);
    wr(3'd0, mkCtrl(1, 1, 0, 0, 0));
    wr(3'd1, 32'hFFFF_FFFA); idle(10);
    wr(3'd5, 32'h1); idle(2);
    wr(3'd1, 32'hFFFF_FFFA);
    while (!mOvf) @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'd5; wrData = 32'h1;
    @(negedge clk); wrEn = 1'b0;
    idle(4);

    curReq = "R11";
    wr(3'd5, 32'h3);
    wr(3'd6, 32'h1); idle(2);
    wr(3'd1, 32'hFFFF_FFFD); idle(8);
    wr(3'd6, 32'h2); idle(2);
    wr(3'd3, 32'h0000_1004);
    wr(3'd0, mkCtrl(1, 1, 0, 0, 1)); idle(10);
    wr(3'd5, 32'h2); idle(3);
    wr(3'd6, 32'h0); idle(3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule